// File: doc/BRIEF.md
# Eight-Line Interrupt Request Controller

This block gathers up to eight interrupt request lines and drives one interrupt output toward a processor. Each request is captured in a request register, filtered through a mask register and ranked by a priority resolver. The output is raised only when the best unmasked request ranks above every interrupt already being serviced. That service state lives in an in-service register, which is set when a request is accepted and cleared by an end-of-interrupt command.

The processor programs the controller through a two-location register port and reads status from it. A setup word (location 0, bit 7 set) selects edge or level capture and normal or automatic end of interrupt. It also clears all service state, and it arms the next location-1 write to load the vector base. Other location-0 words select which register a status read returns, issue end-of-interrupt commands, or switch rotating priority on or off. Plain location-1 writes load the mask.

Acknowledge comes as two single-cycle pulses on `ack`. The first pulse accepts the winning request. The second pulse makes the block present, for one cycle, an 8-bit vector: the programmed base with its low three bits replaced by the accepted line number.

Top module: `irq_hub`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0 at location 1, the request register reads 0 at location 0, capture is edge mode, priority is fixed and the vector base is 0.
- R2: In edge mode a request bit is set by a 0-to-1 change of its input, cleared by the first acknowledge that accepts it, and not set again while the input stays high.
- R3: In level mode (setup word bit 0 = 1) the request register follows the inputs one clock late, and acknowledge does not clear it.
- R4: A mask bit of 1 keeps its line from raising the interrupt output, while the request still shows in the request register. Location-1 reads return the mask.
- R5: Under fixed priority line 0 is highest and line 7 lowest. One cycle after the second acknowledge pulse, `vec_valid` is high for exactly one cycle with `vec_out` = {base[7:3], line}.
- R6: The interrupt output is high only when the winning unmasked request outranks every set in-service bit. A request of equal or lower rank waits.
- R7: The first acknowledge pulse sets the in-service bit of the accepted line. In edge mode it also clears that line's request bit.
- R8: Writing 0x20 at location 0 (non-specific end of interrupt) clears the highest-ranked set in-service bit. Writing 0x30 plus n clears in-service bit n.
- R9: With automatic end of interrupt (setup word bit 1 = 1), acceptance leaves the in-service register unchanged, so lower-ranked requests are not held back.
- R10: Writing 0x09 at location 0 enables rotating priority, and writing 0x08 disables it, which restores fixed order. While rotation is on, the line cleared by an end of interrupt becomes lowest priority.
- R11: Writing 0x41 at location 0 makes location-0 reads return the in-service register; 0x40 makes them return the request register.
- R12: An acknowledge with the interrupt output low yields the vector for line 7 and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, line 0 at bit 0 |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 1 | Register location (0 = command/status, 1 = mask/base) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location on `addr` |
| irq_out | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge pulse, two per acknowledge sequence |
| vec_valid | output | 1 | Vector present on `vec_out` this cycle |
| vec_out | output | 8 | Interrupt vector |

## Verification
The hardest state to reach is a nested one: a lower-ranked request that is already latched but held back by an in-service bit, while a higher-ranked request is accepted on top of it. The stimulus keeps one edge-mode line held high through its acknowledge. It then raises a lower line, and after that a higher one. It retires the two in-service bits with one non-specific and one specific end of interrupt, and at each step it checks that the waiting request surfaces only when nothing above it remains. Rotation is reached the same way: a request left pending while a line is serviced must win over a freshly raised line 0 once rotation has moved the lowest-priority slot.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

   localparam int DATA_W = 8;

   // location-0 write word fields
   localparam int F_SETUP  = 7;
   localparam int F_SELECT = 6;
   localparam int F_EOI    = 5;
   localparam int F_SPEC   = 4;
   localparam int F_ROTATE = 3;
   localparam int F_LEVEL  = 0;
   localparam int F_AUTO   = 1;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_SETUP,
      CMD_SELECT,
      CMD_EOI,
      CMD_ROTATE
   } cmd_e;

   function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] w);
      if (w[F_SETUP])       return CMD_SETUP;
      else if (w[F_SELECT]) return CMD_SELECT;
      else if (w[F_EOI])    return CMD_EOI;
      else if (w[F_ROTATE]) return CMD_ROTATE;
      else                  return CMD_NONE;
   endfunction

endpackage

// File: rtl/irq_hub_capture.sv
`timescale 1ns/1ps
module irq_hub_capture #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 level,
   input  logic                 flush,
   input  logic [NUM_LINES-1:0] clr,
   input  logic [NUM_LINES-1:0] req_in,
   output logic [NUM_LINES-1:0] pend
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic prev_r;
      logic pend_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            pend_r <= 1'b0;
         end else begin
            prev_r <= req_in[i];
            if (flush)
               pend_r <= 1'b0;
            else if (level)
               pend_r <= req_in[i];
            else if (req_in[i] && !prev_r)
               pend_r <= 1'b1;
            else if (clr[i])
               pend_r <= 1'b0;
         end
      end

      assign pend[i] = pend_r;
   end

endmodule

// File: rtl/irq_hub_pick.sv
`timescale 1ns/1ps
module irq_hub_pick #(
   parameter int NUM_LINES = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec,
   input  logic [IDX_W-1:0]     top,
   output logic                 found,
   output logic [IDX_W-1:0]     sel,
   output logic [IDX_W-1:0]     rank
);

   logic [IDX_W-1:0] pos;

   // scan from the lowest rank upward; the last hit (rank 0 side) wins
   always_comb begin
      found = 1'b0;
      sel   = '0;
      rank  = '0;
      pos   = '0;
      for (int k = NUM_LINES - 1; k >= 0; k--) begin
         pos = top + IDX_W'(k);
         if (vec[pos]) begin
            found = 1'b1;
            sel   = pos;
            rank  = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 wr_en,
   input  logic                 addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 irq_out,
   input  logic                 ack,
   output logic                 vec_valid,
   output logic [DATA_W-1:0]    vec_out
);

   localparam int IDX_W = $clog2(NUM_LINES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

   initial begin
      if (NUM_LINES < 2 || NUM_LINES > DATA_W || (NUM_LINES & (NUM_LINES - 1)) != 0)
         $error("irq_hub: NUM_LINES must be a power of two between 2 and %0d", DATA_W);
   end

   // configuration and service state
   logic                 level_q, aeoi_q, rot_q, sel_isr_q, want_base_q;
   logic [DATA_W-1:0]    base_q;
   logic [NUM_LINES-1:0] mask_q, isr_q, isr_d, irr_q, clr_vec;
   logic [IDX_W-1:0]     low_q, low_d, top_w, cur_q;
   logic                 phase_q, vec_valid_q;
   logic [DATA_W-1:0]    vec_q;

   // command decode
   cmd_e cmd;
   logic wr_setup, wr_select, wr_eoi, wr_rotate, wr_hi;
   assign cmd       = decode_cmd(wdata);
   assign wr_setup  = wr_en && !addr && cmd == CMD_SETUP;
   assign wr_select = wr_en && !addr && cmd == CMD_SELECT;
   assign wr_eoi    = wr_en && !addr && cmd == CMD_EOI;
   assign wr_rotate = wr_en && !addr && cmd == CMD_ROTATE;
   assign wr_hi     = wr_en &&  addr;

   // priority resolution
   logic             req_v, isr_v;
   logic [IDX_W-1:0] req_sel, req_rank, isr_sel, isr_rank;

   assign top_w = low_q + 1'b1;

   irq_hub_pick #(.NUM_LINES(NUM_LINES)) u_req_pick (
      .vec(irr_q & ~mask_q), .top(top_w),
      .found(req_v), .sel(req_sel), .rank(req_rank)
   );

   irq_hub_pick #(.NUM_LINES(NUM_LINES)) u_isr_pick (
      .vec(isr_q), .top(top_w),
      .found(isr_v), .sel(isr_sel), .rank(isr_rank)
   );

   assign irq_out = req_v && (!isr_v || req_rank < isr_rank);

   // acknowledge handling
   logic ack1, ack2, take;
   assign ack1 = ack && !phase_q;
   assign ack2 = ack &&  phase_q;
   assign take = ack1 && irq_out;

   assign clr_vec = (take && !level_q) ? (NUM_LINES'(1) << req_sel) : '0;

   irq_hub_capture #(.NUM_LINES(NUM_LINES)) u_capture (
      .clk(clk), .rst_n(rst_n), .level(level_q), .flush(wr_setup),
      .clr(clr_vec), .req_in(irq_in), .pend(irr_q)
   );

   // in-service and rotation next state
   always_comb begin
      isr_d = isr_q;
      low_d = low_q;
      if (wr_setup) begin
         isr_d = '0;
         low_d = LAST;
      end else begin
         if (wr_rotate && !wdata[0])
            low_d = LAST;
         if (wr_eoi) begin
            if (wdata[F_SPEC]) begin
               isr_d[wdata[IDX_W-1:0]] = 1'b0;
               if (rot_q) low_d = wdata[IDX_W-1:0];
            end else if (isr_v) begin
               isr_d[isr_sel] = 1'b0;
               if (rot_q) low_d = isr_sel;
            end
         end
         if (take) begin
            if (!aeoi_q)
               isr_d[req_sel] = 1'b1;
            else if (rot_q)
               low_d = req_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q     <= 1'b0;
         aeoi_q      <= 1'b0;
         rot_q       <= 1'b0;
         sel_isr_q   <= 1'b0;
         want_base_q <= 1'b0;
         base_q      <= '0;
         mask_q      <= '0;
         isr_q       <= '0;
         low_q       <= LAST;
         phase_q     <= 1'b0;
         cur_q       <= '0;
         vec_valid_q <= 1'b0;
         vec_q       <= '0;
      end else begin
         isr_q       <= isr_d;
         low_q       <= low_d;
         vec_valid_q <= 1'b0;
         if (wr_setup) begin
            level_q     <= wdata[F_LEVEL];
            aeoi_q      <= wdata[F_AUTO];
            rot_q       <= 1'b0;
            sel_isr_q   <= 1'b0;
            want_base_q <= 1'b1;
            mask_q      <= '0;
            phase_q     <= 1'b0;
         end else begin
            if (wr_select) sel_isr_q <= wdata[0];
            if (wr_rotate) rot_q     <= wdata[0];
            if (wr_hi) begin
               if (want_base_q) begin
                  base_q      <= wdata;
                  want_base_q <= 1'b0;
               end else begin
                  mask_q <= wdata[NUM_LINES-1:0];
               end
            end
            if (ack1) begin
               phase_q <= 1'b1;
               cur_q   <= take ? req_sel : LAST;
            end else if (ack2) begin
               phase_q     <= 1'b0;
               vec_valid_q <= 1'b1;
               vec_q       <= {base_q[DATA_W-1:IDX_W], cur_q};
            end
         end
      end
   end

   assign vec_valid = vec_valid_q;
   assign vec_out   = vec_q;
   assign rdata     = addr ? DATA_W'(mask_q) : DATA_W'(sel_isr_q ? isr_q : irr_q);

endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
   parameter int NUM_LINES = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 wr_en,
   input logic                 addr,
   input logic [7:0]           wdata,
   input logic                 ack,
   input logic                 irq_out,
   input logic                 vec_valid,
   input logic [NUM_LINES-1:0] irr_q,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] isr_q,
   input logic                 level_q,
   input logic                 aeoi_q,
   input logic                 phase_q
);

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irr_q & ~mask_q) != '0); // R4

   AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid); // R5

   AST_VEC_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_valid) |-> $past(ack) && $past(phase_q)); // R5

   AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !phase_q && !wr_en |=> $countones(isr_q) <= $past($countones(isr_q)) + 1); // R7

   AST_EOI_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !addr && wdata[7:5] == 3'b001 && !ack
      |=> $countones(isr_q) <= $past($countones(isr_q))); // R8

   AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      aeoi_q && !wr_en |=> $stable(isr_q)); // R9

   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      level_q && !wr_en |=> irr_q == $past(irq_in)); // R3

endmodule

bind irq_hub irq_hub_chk #(.NUM_LINES(NUM_LINES)) u_irq_hub_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .ack(ack), .irq_out(irq_out), .vec_valid(vec_valid),
   .irr_q(irr_q), .mask_q(mask_q), .isr_q(isr_q), .level_q(level_q),
   .aeoi_q(aeoi_q), .phase_q(phase_q)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       wr_en = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = '0;
   logic       ack = 1'b0;
   logic [7:0] rdata, vec_out;
   logic       irq_out, vec_valid;

   always #10 clk = ~clk;

   irq_hub #(.NUM_LINES(8)) i_irq_hub (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .ack(ack),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected vectors as the design presents them
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R5 unexpected vector: actual %h expected none", vec_out);
         end else begin
            automatic string      t = tag_q.pop_front();
            automatic logic [7:0] e = exp_q.pop_front();
            chk(t, vec_out, e);
         end
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 1'b0;
   endtask

   task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1 chk(tag, rdata, exp);
      addr = 1'b0;
   endtask

   task automatic irq_chk(input logic exp, input string tag);
      #1 chk(tag, {7'd0, irq_out}, {7'd0, exp});
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
   endtask

   // driver: pushes the expected vector, then issues the two pulses
   task automatic do_ack(input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic run_tests();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      irq_chk(1'b0, "R1 irq low");
      rd_chk(1'b1, 8'h00, "R1 mask");
      rd_chk(1'b0, 8'h00, "R1 request reg");

      // edge mode, base 0x40
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h40);
      set_irq(8'h08);
      irq_chk(1'b1, "R2 edge raises irq");
      rd_chk(1'b0, 8'h08, "R2 request latched");
      do_ack(8'h43, "R5 vector line3");
      rd_chk(1'b0, 8'h00, "R2/R7 request cleared by ack");
      wr(1'b0, 8'h41);
      rd_chk(1'b0, 8'h08, "R7 in-service bit3 R11");
      repeat (3) @(negedge clk);
      irq_chk(1'b0, "R2 held input no retrigger");

      // nesting
      set_irq(8'h28);
      irq_chk(1'b0, "R6 lower line waits");
      set_irq(8'h2A);
      irq_chk(1'b1, "R6 higher line interrupts");
      do_ack(8'h41, "R6 nested vector line1");
      rd_chk(1'b0, 8'h0A, "R7 nested in-service");
      wr(1'b0, 8'h20);
      rd_chk(1'b0, 8'h08, "R8 non-specific clears top");
      irq_chk(1'b0, "R6 line5 still below line3");
      wr(1'b0, 8'h33);
      rd_chk(1'b0, 8'h00, "R8 specific clears bit3");
      irq_chk(1'b1, "R6 line5 released");
      do_ack(8'h45, "R5 vector line5");
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // masking
      wr(1'b0, 8'h40);
      wr(1'b1, 8'h04);
      set_irq(8'h04);
      irq_chk(1'b0, "R4 masked line silent");
      rd_chk(1'b0, 8'h04, "R4 masked request visible");
      rd_chk(1'b1, 8'h04, "R4 mask readback");
      wr(1'b1, 8'h00);
      irq_chk(1'b1, "R4 unmask raises irq");
      do_ack(8'h42, "R4 vector line2");
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // fixed priority
      set_irq(8'h90);
      do_ack(8'h44, "R5 fixed line4 before line7");
      wr(1'b0, 8'h20);
      do_ack(8'h47, "R5 then line7");
      wr(1'b0, 8'h20);
      set_irq(8'h00);
      irq_chk(1'b0, "R8 all retired");

      // spurious acknowledge
      do_ack(8'h47, "R12 spurious vector");
      wr(1'b0, 8'h41);
      rd_chk(1'b0, 8'h00, "R12 in-service unchanged");

      // level mode, base 0x80
      wr(1'b0, 8'h81);
      wr(1'b1, 8'h80);
      set_irq(8'h40);
      rd_chk(1'b0, 8'h40, "R3 level request");
      irq_chk(1'b1, "R3 level irq");
      set_irq(8'h00);
      rd_chk(1'b0, 8'h00, "R3 level drop");
      irq_chk(1'b0, "R3 level irq drop");
      set_irq(8'h40);
      do_ack(8'h86, "R3 level vector");
      rd_chk(1'b0, 8'h40, "R3 ack keeps level request");
      irq_chk(1'b0, "R6 same line blocked");
      wr(1'b0, 8'h20);
      irq_chk(1'b1, "R8 eoi releases level line");
      set_irq(8'h00);

      // automatic end of interrupt, base 0x00
      wr(1'b0, 8'h82);
      wr(1'b1, 8'h00);
      set_irq(8'h04);
      do_ack(8'h02, "R9 auto vector");
      wr(1'b0, 8'h41);
      rd_chk(1'b0, 8'h00, "R9 in-service empty");
      set_irq(8'h05);
      irq_chk(1'b1, "R9 lower line not blocked");
      do_ack(8'h00, "R9 line0 vector");
      set_irq(8'h00);

      // rotating priority, base 0x20
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h20);
      wr(1'b0, 8'h09);
      set_irq(8'h09);
      do_ack(8'h20, "R10 line0 first");
      wr(1'b0, 8'h20);
      set_irq(8'h00);
      set_irq(8'h01);
      do_ack(8'h23, "R10 line0 rotated below line3");
      wr(1'b0, 8'h20);
      do_ack(8'h20, "R10 line0 after line3");
      wr(1'b0, 8'h20);
      set_irq(8'h00);
      wr(1'b0, 8'h08);
      set_irq(8'h81);
      do_ack(8'h20, "R10 fixed order restored");
      wr(1'b0, 8'h20);
      do_ack(8'h27, "R10 line7 last");
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      repeat (4) @(negedge clk);
      chk("R5 all vectors seen", 8'(exp_q.size()), 8'd0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule